// File: doc/BRIEF.md
# In-Order Retirement Ring Buffer

This block keeps instructions that execute out of order in program order until they commit. The front end pushes each instruction into the next ring slot and gets back that slot's index. The index is the tag that the execution units later use to report a result. A result is held in its slot, and the register-file write is released only when the slot reaches the oldest position. Up to a fixed number of finished slots commit together each cycle, starting with the oldest.

Faults recorded at write-back sit in their slot until that slot is the oldest. At that point the whole ring is discarded and a fault-taken pulse is raised with the faulting instruction's PC. A mispredicted branch can be reported at any time. It removes every slot younger than the branch in the same cycle. The branch itself stays and commits later like any other instruction. Instructions without a destination register, such as stores and branches, still take a slot and commit in order, but they write no register.

The allocation side is a valid/ready stream. An instruction transfers on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls when the ring holds DEPTH-1 entries, and also during a cycle that carries a branch flush or a fault-taken event. The retire lanes have no back-pressure: the register file must take every `ret_we` write in the cycle it appears. Write-back is a plain strobe.

Top module: `rob_core`

## Requirements
- R1: After reset the ring is empty: `alloc_ready`=1, `alloc_tag`=0, no `ret_valid` bit is set, and `exc_taken`=0.
- R2: Accepted allocations receive consecutive tags (the 3-bit slot index), incrementing by one modulo 8 from the previous tag, with no gaps.
- R3: With 7 entries held (empty is head equal to tail, full is tail+1 mod 8 equal to head), `alloc_ready` is 0 and a presented instruction is not taken.
- R4: Results are returned on the retire lanes in program order, carrying the value, destination and PC given at write-back and allocation. Lane 0 is the oldest.
- R5: While the oldest entry has not been written back, nothing retires, even if every younger entry is complete.
- R6: At most 2 entries retire per cycle. They are contiguous from the oldest, and lane 1 is set only together with lane 0, so k completed entries drain in ceil(k/2) cycles.
- R7: An entry allocated without a destination retires with `ret_valid` set and `ret_we` clear.
- R8: A faulted entry does nothing until it is oldest. Then, for one cycle, `exc_taken`=1, `exc_pc` is its PC and no lane retires. Afterwards the ring is empty and the next tag equals the faulted entry's tag.
- R9: A branch flush on tag t removes all younger entries at once and blocks allocation in that cycle. The next tag is t+1 mod 8, and the branch still retires later.
- R10: A write-back to a tag that is not awaiting a result is ignored. A later allocation into that slot still waits for its own write-back, and it retires with the new value.
- R11: An allocation and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Instruction offered for allocation |
| alloc_ready | output | 1 | Ring can take the instruction this cycle |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | REG_W | Destination register number |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_tag | output | TAG_W | Slot index given to the offered instruction |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | TAG_W | Slot being written back |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Result is a fault |
| br_flush_valid | input | 1 | Mispredicted branch resolved |
| br_tag | input | TAG_W | Tag of that branch |
| ret_valid | output | RET_W | Lane commits an entry this cycle |
| ret_we | output | RET_W | Lane writes the register file |
| ret_dst | output | RET_W*REG_W | Per-lane destination register |
| ret_data | output | RET_W*DATA_W | Per-lane result value |
| ret_pc | output | RET_W*PC_W | Per-lane PC |
| exc_taken | output | 1 | Oldest entry faulted; ring discarded |
| exc_pc | output | PC_W | PC of the faulting entry |

## Verification
The hardest situation to reach is a branch flush landing on a ring that has wrapped, with completed wrong-path entries behind it and a stale write-back arriving after the slot has been freed. The bench first runs a sweep over every fill level from 1 to 7. Each fill is completed youngest-first, so the head pointer ends up at a different ring position for each later scenario. The flush scenario then completes the wrong-path entries before flushing them, sends a write-back to a freed slot, and reallocates that slot, so that the ignored write can be seen at the retire lanes.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_DONE  = 2'd2,
    SLOT_FAULT = 2'd3
  } slot_st_e;

  function automatic uint_t ring_fwd(input uint_t a, input uint_t b, input uint_t n);
    return (a + b) % n;
  endfunction

  function automatic uint_t ring_dist(input uint_t from_p, input uint_t to_p, input uint_t n);
    return (to_p + n - from_p) % n;
  endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RET_W = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(RET_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [CNT_W-1:0] ret_cnt,
  input  logic             flush_all,
  input  logic             br_ok,
  input  logic [TAG_W-1:0] br_tag,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [TAG_W-1:0] occ,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (flush_all) begin
      tail <= head;
    end else begin
      head <= TAG_W'(ring_fwd(uint_t'(head), uint_t'(ret_cnt), DEPTH));
      if (br_ok)
        tail <= TAG_W'(ring_fwd(uint_t'(br_tag), 1, DEPTH));
      else if (alloc_fire)
        tail <= TAG_W'(ring_fwd(uint_t'(tail), 1, DEPTH));
    end
  end

  assign occ  = TAG_W'(ring_dist(uint_t'(head), uint_t'(tail), DEPTH));
  assign full = (uint_t'(occ) == uint_t'(DEPTH - 1));

  // R9
  br_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_ok && !flush_all) |=> tail == TAG_W'(ring_fwd(uint_t'($past(br_tag)), 1, DEPTH)));

  // R8
  exc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> occ == '0);
endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  tail,
  input  logic              alloc_has_dst,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic [DEPTH-1:0]  kill_vec,
  input  logic [DEPTH-1:0]  free_vec,
  output slot_st_e          st     [DEPTH],
  output logic [DATA_W-1:0] data_q [DEPTH],
  output logic [REG_W-1:0]  dst_q  [DEPTH],
  output logic              dstv_q [DEPTH],
  output logic [PC_W-1:0]   pc_q   [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, hit;
    assign take = alloc_fire && (uint_t'(tail) == uint_t'(i));
    assign hit  = wb_valid && (uint_t'(wb_tag) == uint_t'(i)) && (st[i] == SLOT_WAIT);

    always_ff @(posedge clk) begin
      if (!rst_n)
        st[i] <= SLOT_EMPTY;
      else if (kill_vec[i] || free_vec[i])
        st[i] <= SLOT_EMPTY;
      else if (take)
        st[i] <= SLOT_WAIT;
      else if (hit)
        st[i] <= wb_exc ? SLOT_FAULT : SLOT_DONE;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        dst_q[i]  <= alloc_dst;
        dstv_q[i] <= alloc_has_dst;
        pc_q[i]   <= alloc_pc;
      end
      if (hit && !take && !kill_vec[i])
        data_q[i] <= wb_data;
    end

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> st[i] == SLOT_EMPTY);

    // R10
    stale_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && uint_t'(wb_tag) == uint_t'(i) && st[i] != SLOT_WAIT
       && !kill_vec[i] && !free_vec[i] && !take) |=> st[i] == $past(st[i]));
  end
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RET_W = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(RET_W + 1)
) (
  input  logic [TAG_W-1:0] head,
  input  logic [TAG_W-1:0] occ,
  input  slot_st_e         st [DEPTH],
  input  logic             br_ok,
  input  logic [TAG_W-1:0] br_ofs,
  output logic [RET_W-1:0] lane_go,
  output logic [TAG_W-1:0] lane_idx [RET_W],
  output logic [CNT_W-1:0] ret_cnt,
  output logic             exc_hit
);
  always_comb begin
    logic alive;
    logic go;
    logic [TAG_W-1:0] idx;
    alive   = 1'b1;
    ret_cnt = '0;
    for (int i = 0; i < RET_W; i++) begin
      idx = TAG_W'(ring_fwd(uint_t'(head), uint_t'(i), DEPTH));
      lane_idx[i] = idx;
      go = alive && (uint_t'(i) < uint_t'(occ))
           && (!br_ok || uint_t'(i) <= uint_t'(br_ofs))
           && (st[idx] == SLOT_DONE);
      lane_go[i] = go;
      alive = go;
      if (go) ret_cnt = ret_cnt + CNT_W'(1);
    end
    exc_hit = (occ != '0) && (st[head] == SLOT_FAULT);
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int RET_W  = 2,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(RET_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  output logic                    alloc_ready,
  input  logic                    alloc_has_dst,
  input  logic [REG_W-1:0]        alloc_dst,
  input  logic [PC_W-1:0]         alloc_pc,
  output logic [TAG_W-1:0]        alloc_tag,
  input  logic                    wb_valid,
  input  logic [TAG_W-1:0]        wb_tag,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_exc,
  input  logic                    br_flush_valid,
  input  logic [TAG_W-1:0]        br_tag,
  output logic [RET_W-1:0]        ret_valid,
  output logic [RET_W-1:0]        ret_we,
  output logic [RET_W*REG_W-1:0]  ret_dst,
  output logic [RET_W*DATA_W-1:0] ret_data,
  output logic [RET_W*PC_W-1:0]   ret_pc,
  output logic                    exc_taken,
  output logic [PC_W-1:0]         exc_pc
);
  logic [TAG_W-1:0]  head, tail, occ, br_ofs;
  logic              full, br_ok, exc_hit, alloc_fire;
  logic [CNT_W-1:0]  ret_cnt;
  logic [RET_W-1:0]  lane_go;
  logic [TAG_W-1:0]  lane_idx [RET_W];
  logic [DEPTH-1:0]  kill_vec, free_vec;
  slot_st_e          st     [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic              dstv_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  assign br_ofs      = TAG_W'(ring_dist(uint_t'(head), uint_t'(br_tag), DEPTH));
  assign br_ok       = br_flush_valid && (br_ofs < occ);
  assign alloc_ready = !full && !br_flush_valid && !exc_hit;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_cnt(ret_cnt),
    .flush_all(exc_hit), .br_ok(br_ok), .br_tag(br_tag),
    .head(head), .tail(tail), .occ(occ), .full(full)
  );

  rob_slot_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .PC_W(PC_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail(tail),
    .alloc_has_dst(alloc_has_dst), .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
    .kill_vec(kill_vec), .free_vec(free_vec),
    .st(st), .data_q(data_q), .dst_q(dst_q), .dstv_q(dstv_q), .pc_q(pc_q)
  );

  rob_retire_pick #(.DEPTH(DEPTH), .RET_W(RET_W)) u_pick (
    .head(head), .occ(occ), .st(st), .br_ok(br_ok), .br_ofs(br_ofs),
    .lane_go(lane_go), .lane_idx(lane_idx), .ret_cnt(ret_cnt), .exc_hit(exc_hit)
  );

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      uint_t ofs;
      ofs = ring_dist(uint_t'(head), uint_t'(j), DEPTH);
      kill_vec[j] = exc_hit ||
                    (br_ok && ofs > uint_t'(br_ofs) && ofs < uint_t'(occ));
    end
  end

  always_comb begin
    free_vec = '0;
    for (int i = 0; i < RET_W; i++)
      if (lane_go[i]) free_vec[lane_idx[i]] = 1'b1;
  end

  for (genvar i = 0; i < RET_W; i++) begin : g_lane
    assign ret_valid[i]                  = lane_go[i];
    assign ret_we[i]                     = lane_go[i] && dstv_q[lane_idx[i]];
    assign ret_dst[i*REG_W +: REG_W]     = dst_q[lane_idx[i]];
    assign ret_data[i*DATA_W +: DATA_W]  = data_q[lane_idx[i]];
    assign ret_pc[i*PC_W +: PC_W]        = pc_q[lane_idx[i]];
    if (i > 0) begin : g_ord
      // R6
      lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[i] |-> ret_valid[i-1]);
    end
  end

  assign exc_taken = exc_hit;
  assign exc_pc    = pc_q[head];

  // R5
  head_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[0] |-> st[head] == SLOT_DONE);

  // R8
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> ret_valid == '0);
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_has_dst = 1'b0;
  logic [4:0]  alloc_dst = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        wb_valid = 1'b0, wb_exc = 1'b0;
  logic [2:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic        br_flush_valid = 1'b0;
  logic [2:0]  br_tag = '0;
  logic [1:0]  ret_valid, ret_we;
  logic [9:0]  ret_dst;
  logic [63:0] ret_data, ret_pc;
  logic        exc_taken;
  logic [31:0] exc_pc;

  int checks = 0, failures = 0;
  int exp_tail = 0;
  int log_n = 0, ret_cycles = 0, exc_n = 0;
  logic [31:0] log_pc [256];
  logic [31:0] log_data [256];
  logic        log_we [256];
  logic [4:0]  log_dst [256];
  logic [31:0] exc_pc_last = '0;

  always #4 clk = ~clk;

  rob_core u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_has_dst(alloc_has_dst), .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
    .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_exc(wb_exc), .br_flush_valid(br_flush_valid), .br_tag(br_tag),
    .ret_valid(ret_valid), .ret_we(ret_we), .ret_dst(ret_dst), .ret_data(ret_data),
    .ret_pc(ret_pc), .exc_taken(exc_taken), .exc_pc(exc_pc)
  );

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (ret_valid != 2'b00) ret_cycles++;
      for (int i = 0; i < 2; i++) begin
        if (ret_valid[i] && log_n < 256) begin
          log_pc[log_n]   = ret_pc[i*32 +: 32];
          log_data[log_n] = ret_data[i*32 +: 32];
          log_we[log_n]   = ret_we[i];
          log_dst[log_n]  = ret_dst[i*5 +: 5];
          log_n++;
        end
      end
      if (exc_taken) begin
        exc_n++;
        exc_pc_last = exc_pc;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_alloc(input bit hd, input logic [4:0] d, input logic [31:0] pc,
                          input bit exp_rdy, input string rq);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_has_dst = hd; alloc_dst = d; alloc_pc = pc;
    #2;
    chk(alloc_ready == exp_rdy, rq, alloc_ready, exp_rdy);
    if (exp_rdy) begin
      chk(alloc_tag == 3'(exp_tail), "R2 tag", alloc_tag, exp_tail);
      exp_tail = (exp_tail + 1) % 8;
    end
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_wb(input int tag, input logic [31:0] d, input bit ex);
    @(negedge clk);
    wb_valid = 1'b1; wb_tag = 3'(tag); wb_data = d; wb_exc = ex;
    @(posedge clk); #1;
    wb_valid = 1'b0; wb_exc = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  function automatic logic [31:0] val_of(input logic [31:0] pc);
    return pc * 3 + 7;
  endfunction

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle(1);
    chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
    chk(alloc_tag == 3'd0, "R1 tag", alloc_tag, 0);
    chk(ret_valid == 2'b00, "R1 ret_valid", ret_valid, 0);
    chk(exc_taken == 1'b0, "R1 exc", exc_taken, 0);

    // Sweep over fill levels, youngest completes first (R4 R5 R6 R7 R3)
    for (int k = 1; k <= 7; k++) begin
      first = exp_tail;
      for (int j = 0; j < k; j++)
        do_alloc(j != 1, 5'(j + 1), 32'(100 * k + j), 1'b1, "R2 alloc");
      if (k == 7) begin
        do_alloc(1'b1, 5'd9, 32'd9999, 1'b0, "R3 full");
      end
      log_n = 0; ret_cycles = 0;
      for (int j = k - 1; j >= 1; j--)
        do_wb((first + j) % 8, val_of(32'(100 * k + j)), 1'b0);
      idle(2);
      chk(log_n == 0, "R5 head gate", log_n, 0);
      do_wb(first, val_of(32'(100 * k)), 1'b0);
      idle(6);
      chk(log_n == k, "R4 count", log_n, k);
      for (int j = 0; j < k; j++) begin
        chk(log_pc[j] == 32'(100 * k + j), "R4 order", log_pc[j], 100 * k + j);
        chk(log_data[j] == val_of(32'(100 * k + j)), "R4 data", log_data[j], val_of(32'(100 * k + j)));
        chk(log_we[j] == (j != 1), "R7 we", log_we[j], j != 1);
        if (j != 1) chk(log_dst[j] == 5'(j + 1), "R4 dst", log_dst[j], j + 1);
      end
      chk(ret_cycles == (k + 1) / 2, "R6 width", ret_cycles, (k + 1) / 2);
    end

    // R11 allocation together with retirement
    first = exp_tail;
    for (int j = 0; j < 6; j++)
      do_alloc(1'b1, 5'(j), 32'(500 + j), 1'b1, "R2 alloc");
    log_n = 0;
    do_wb(first, val_of(32'd500), 1'b0);
    do_alloc(1'b1, 5'd6, 32'd506, 1'b1, "R11 alloc with retire");
    chk(log_n == 1, "R11 retired", log_n, 1);
    do_alloc(1'b1, 5'd7, 32'd507, 1'b1, "R11 occupancy");
    do_alloc(1'b1, 5'd8, 32'd508, 1'b0, "R3 full after R11");
    for (int j = 1; j < 8; j++)
      do_wb((first + j) % 8, val_of(32'(500 + j)), 1'b0);
    idle(6);
    chk(log_n == 8, "R11 count", log_n, 8);
    for (int j = 0; j < 8; j++)
      chk(log_pc[j] == 32'(500 + j), "R11 order", log_pc[j], 500 + j);

    // R8 fault waits for head
    first = exp_tail;
    for (int j = 0; j < 4; j++)
      do_alloc(1'b1, 5'(j), 32'(600 + j), 1'b1, "R2 alloc");
    log_n = 0; exc_n = 0;
    do_wb((first + 1) % 8, 32'd1, 1'b1);
    do_wb((first + 2) % 8, 32'd2, 1'b0);
    do_wb((first + 3) % 8, 32'd3, 1'b0);
    idle(2);
    chk(exc_n == 0 && log_n == 0, "R8 wait", exc_n + log_n, 0);
    do_wb(first, val_of(32'd600), 1'b0);
    idle(4);
    chk(log_n == 1, "R8 older retires", log_n, 1);
    chk(log_pc[0] == 32'd600, "R8 older pc", log_pc[0], 600);
    chk(exc_n == 1, "R8 taken once", exc_n, 1);
    chk(exc_pc_last == 32'd601, "R8 exc_pc", exc_pc_last, 601);
    exp_tail = (first + 1) % 8;
    do_alloc(1'b1, 5'd3, 32'd700, 1'b1, "R8 ring empty");
    do_wb((first + 1) % 8, val_of(32'd700), 1'b0);
    idle(4);
    chk(log_n == 2 && log_pc[1] == 32'd700, "R8 after fault", log_pc[1], 700);

    // R9 branch flush, R10 stale write-back
    first = exp_tail;
    for (int j = 0; j < 5; j++)
      do_alloc(j != 1, 5'(j + 1), 32'(800 + j), 1'b1, "R2 alloc");
    log_n = 0;
    do_wb((first + 3) % 8, 32'd33, 1'b0);
    do_wb((first + 4) % 8, 32'd44, 1'b0);
    @(negedge clk);
    br_flush_valid = 1'b1; br_tag = 3'((first + 1) % 8);
    alloc_valid = 1'b1; alloc_has_dst = 1'b1; alloc_pc = 32'd999;
    #2;
    chk(alloc_ready == 1'b0, "R9 alloc blocked", alloc_ready, 0);
    @(posedge clk); #1;
    br_flush_valid = 1'b0; alloc_valid = 1'b0;
    exp_tail = (first + 2) % 8;
    do_alloc(1'b1, 5'd10, 32'd810, 1'b1, "R9 next tag");
    do_wb((first + 3) % 8, 32'd1234, 1'b0);
    do_alloc(1'b1, 5'd11, 32'd811, 1'b1, "R10 realloc");
    do_wb(first, val_of(32'd800), 1'b0);
    do_wb((first + 1) % 8, 32'd0, 1'b0);
    do_wb((first + 2) % 8, val_of(32'd810), 1'b0);
    idle(6);
    chk(log_n == 3, "R10 stale write ignored", log_n, 3);
    chk(log_pc[0] == 32'd800, "R9 older", log_pc[0], 800);
    chk(log_pc[1] == 32'd801 && log_we[1] == 1'b0, "R9 branch kept", log_pc[1], 801);
    chk(log_pc[2] == 32'd810, "R9 wrong path removed", log_pc[2], 810);
    do_wb((first + 3) % 8, val_of(32'd811), 1'b0);
    idle(4);
    chk(log_n == 4, "R10 count", log_n, 4);
    chk(log_data[3] == val_of(32'd811), "R10 new value", log_data[3], val_of(32'd811));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule